// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block forms the status byte that a flash device returns on bus reads while an embedded program or erase runs, while an erase is suspended, and while a failed operation waits to be cleared. The bus logic supplies the current operation, the bit 7 value being programmed, the erase progress flags, the error indications, whether the read address falls in a block that is being erased, and a read strobe. The block returns the status byte. It also returns a select flag that tells the bus logic to return array data instead of status.

Two toggle flops give the host a way to poll for completion. One flips on every status read while the controller is running. The other flips only on reads from addresses that the erase covers, so the host can find out which blocks are being erased or have failed. A polling bit returns the inverse of the data being written, so the host can compare it against the value it intends to store.

Top module: `flash_status_gen`

## Requirements
- R1: After reset both toggle flops are 0 and the error flag is clear. With op_i idle (2'b00, and 2'b11 is treated the same way) and no error, array_sel_o is 1 and status_o is 8'h00.
- R2: With op_i = 2'b01 (program), status_o[7] equals the inverse of pgm_dq7_i.
- R3: With op_i = 2'b10 (erase), status_o[7] reads 0 while the erase is running. While suspended_i is 1, a read from an erasing block gives status_o[7] = 1.
- R4: status_o[6] flips after each status read (rd_i high while array_sel_o is 0), whatever the address, unless an erase is suspended. While an erase is suspended it holds its value.
- R5: status_o[5] is set one cycle after fail_i. It stays set until reset_cmd_i clears it, and clearing takes priority over setting. While it is set, status is returned even when op_i is idle.
- R6: During an erase, status_o[3] reads 0 while erase_started_i is 0 and no suspend is active. It reads 1 once erase_started_i or suspended_i is 1. During a program it reads 0.
- R7: During an erase, including an erase suspend, status_o[2] flips after each status read with in_erase_blk_i = 1. Status reads with in_erase_blk_i = 0, and all reads during a program, leave it unchanged.
- R8: While the error flag is set, status_o[2] flips only on reads with blk_fail_i = 1, whatever the value of in_erase_blk_i.
- R9: During an erase suspend with no error, a read with in_erase_blk_i = 0 gives array_sel_o = 1 and status_o = 8'h00, and neither toggle flop advances.
- R10: status_o bits 0, 1 and 4 always read 0.
- R11: The toggle flops change only in cycles where rd_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 idle, 01 program, 10 erase, 11 idle |
| pgm_dq7_i | input | 1 | Bit 7 of the data being programmed |
| erase_started_i | input | 1 | Block-selection window closed, erase running |
| suspended_i | input | 1 | Erase suspended |
| fail_i | input | 1 | Operation failure pulse |
| reset_cmd_i | input | 1 | Read/reset command seen, clears the error flag |
| in_erase_blk_i | input | 1 | Read address lies in a block selected for erase |
| blk_fail_i | input | 1 | Read address lies in a block that failed to erase |
| rd_i | input | 1 | Bus read strobe, one per cycle |
| status_o | output | 8 | Status byte |
| array_sel_o | output | 1 | 1: return array data instead of status |

## Verification
The hardest situation to reach combines a suspended erase with addresses that alternate between erasing and non-erasing blocks. In that state, bit 6 must hold while bit 2 keeps advancing, and the reads that go to the array must leave both flops unchanged. The stimulus reaches it by first advancing both flops with active-erase reads, so that their values are known and not at reset. It then raises the suspend flag and interleaves the two address classes. The failed-erase case is reached in the same way: fail_i is pulsed in the middle of an erase, and reads are then steered with blk_fail_i against in_erase_blk_i.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  localparam int STAT_W   = 8;
  localparam int POLL_POS = 7;
  localparam int TOG_POS  = 6;
  localparam int FAIL_POS = 5;
  localparam int ERS_POS  = 3;
  localparam int ALT_POS  = 2;
endpackage

// File: rtl/fsg_toggle.sv
module fsg_toggle #(
  parameter bit INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= INIT;
    else if (adv_i) q_q <= ~q_q;
  end

  assign q_o = q_q;
endmodule

// File: rtl/fsg_err_latch.sv
module fsg_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (clr_i) q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
  end

  assign q_o = q_q;

  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q && !clr_i) |=> q_q);
  // R5
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_q);
endmodule

// File: rtl/fsg_mode_dec.sv
module fsg_mode_dec
  import flash_stat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  logic pgm_dq7_i,
  input  logic started_i,
  input  logic susp_i,
  input  logic err_i,
  input  logic in_ers_i,
  input  logic blk_fail_i,
  input  logic rd_i,
  output logic arr_sel_o,
  output logic adv_tog_o,
  output logic adv_alt_o,
  output logic poll_o,
  output logic ers_o
);
  logic is_ers, is_prg, susp, busy, stat_rd;

  always_comb begin
    is_ers  = (op_i == OP_ERASE);
    is_prg  = (op_i == OP_PROG);
    susp    = susp_i && is_ers;
    busy    = is_ers || is_prg || err_i;
    // suspended erase: non-erasing blocks read the array
    arr_sel_o = !busy || (susp && !in_ers_i && !err_i);
    stat_rd   = rd_i && !arr_sel_o;
    adv_tog_o = stat_rd && !susp;
    adv_alt_o = stat_rd && (err_i ? blk_fail_i : (is_ers && in_ers_i));
    if (susp)        poll_o = 1'b1;
    else if (is_prg) poll_o = ~pgm_dq7_i;
    else             poll_o = 1'b0;
    ers_o = is_ers && (started_i || susp);
  end

  // R3
  erase_poll_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ERASE && !susp_i) |-> !poll_o);
  // R9
  susp_no_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ERASE && susp_i && !in_ers_i && !err_i) |-> (!adv_tog_o && !adv_alt_o));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic              pgm_dq7_i,
  input  logic              erase_started_i,
  input  logic              suspended_i,
  input  logic              fail_i,
  input  logic              reset_cmd_i,
  input  logic              in_erase_blk_i,
  input  logic              blk_fail_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] status_o,
  output logic              array_sel_o
);
  op_e  op;
  logic err_q, tog_q, alt_q;
  logic arr_sel, adv_tog, adv_alt, poll, ers_bit;

  assign op = op_e'(op_i);

  fsg_err_latch u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (fail_i),
    .clr_i (reset_cmd_i),
    .q_o   (err_q)
  );

  fsg_mode_dec u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .pgm_dq7_i (pgm_dq7_i),
    .started_i (erase_started_i),
    .susp_i    (suspended_i),
    .err_i     (err_q),
    .in_ers_i  (in_erase_blk_i),
    .blk_fail_i(blk_fail_i),
    .rd_i      (rd_i),
    .arr_sel_o (arr_sel),
    .adv_tog_o (adv_tog),
    .adv_alt_o (adv_alt),
    .poll_o    (poll),
    .ers_o     (ers_bit)
  );

  fsg_toggle u_tog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv_tog),
    .q_o   (tog_q)
  );

  fsg_toggle u_alt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv_alt),
    .q_o   (alt_q)
  );

  always_comb begin
    status_o = '0;
    if (!arr_sel) begin
      status_o[POLL_POS] = poll;
      status_o[TOG_POS]  = tog_q;
      status_o[FAIL_POS] = err_q;
      status_o[ERS_POS]  = ers_bit;
      status_o[ALT_POS]  = alt_q;
    end
  end

  assign array_sel_o = arr_sel;

  // R2
  prog_poll_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01) |-> (status_o[POLL_POS] == !pgm_dq7_i));
  // R4
  tog_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !array_sel_o && !(op_i == 2'b10 && suspended_i)) |=> (tog_q != $past(tog_q)));
  // R11
  no_rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ($stable(tog_q) && $stable(alt_q)));
  // R9
  susp_array_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10 && suspended_i && !in_erase_blk_i && !err_q) |-> (array_sel_o && status_o == '0));
endmodule

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op = 2'b00;
  logic       dq7 = 1'b0, started = 1'b0, susp = 1'b0, fail = 1'b0, rcmd = 1'b0;
  logic       in_ers = 1'b0, bfail = 1'b0, rd = 1'b0;
  logic [7:0] status;
  logic       arr;
  int         n_chk = 0, n_bad = 0;
  logic       e6 = 1'b0, e2 = 1'b0;
  logic [7:0] s;
  logic       a;

  always #2 clk = ~clk;

  flash_status_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .pgm_dq7_i(dq7),
    .erase_started_i(started), .suspended_i(susp), .fail_i(fail),
    .reset_cmd_i(rcmd), .in_erase_blk_i(in_ers), .blk_fail_i(bfail),
    .rd_i(rd), .status_o(status), .array_sel_o(arr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one read: sample before the edge, flops update at the edge
  task automatic do_read();
    @(negedge clk);
    rd = 1'b1;
    #1;
    s = status;
    a = arr;
    @(posedge clk);
    #1 rd = 1'b0;
  endtask

  task automatic peek();
    @(negedge clk);
    #1;
    s = status;
    a = arr;
  endtask

  task automatic t_reset();
    peek();
    chk("R1 array sel", {7'd0, a}, 8'h01);
    chk("R1 status", s, 8'h00);
    op = 2'b11;
    peek();
    chk("R1 op 11 idle", {7'd0, a}, 8'h01);
    op = 2'b00;
  endtask

  task automatic t_program();
    op = 2'b01;
    dq7 = 1'b1;
    do_read();
    chk("R2 poll dq7=1", {7'd0, s[7]}, 8'h00);
    chk("R4 tog first", {7'd0, s[6]}, {7'd0, e6});
    chk("R10 reserved", {5'd0, s[4], s[1], s[0]}, 8'h00);
    chk("R6 prog bit3", {7'd0, s[3]}, 8'h00);
    e6 = ~e6;
    dq7 = 1'b0;
    in_ers = 1'b1;
    do_read();
    chk("R2 poll dq7=0", {7'd0, s[7]}, 8'h01);
    chk("R4 tog second", {7'd0, s[6]}, {7'd0, e6});
    chk("R7 prog alt hold", {7'd0, s[2]}, {7'd0, e2});
    e6 = ~e6;
    repeat (3) @(posedge clk);
    peek();
    chk("R11 no strobe hold", {6'd0, s[6], s[2]}, {6'd0, e6, e2});
    in_ers = 1'b0;
    op = 2'b00;
  endtask

  task automatic t_erase();
    op = 2'b10;
    started = 1'b0;
    in_ers = 1'b1;
    do_read();
    chk("R6 window open", {7'd0, s[3]}, 8'h00);
    chk("R3 erase poll", {7'd0, s[7]}, 8'h00);
    chk("R7 alt erasing", {7'd0, s[2]}, {7'd0, e2});
    e6 = ~e6;
    e2 = ~e2;
    in_ers = 1'b0;
    do_read();
    chk("R7 alt after erasing read", {7'd0, s[2]}, {7'd0, e2});
    chk("R4 tog any addr", {7'd0, s[6]}, {7'd0, e6});
    e6 = ~e6;
    started = 1'b1;
    do_read();
    chk("R7 non-erasing no adv", {7'd0, s[2]}, {7'd0, e2});
    chk("R6 started", {7'd0, s[3]}, 8'h01);
    e6 = ~e6;
  endtask

  task automatic t_suspend();
    susp = 1'b1;
    in_ers = 1'b1;
    do_read();
    chk("R3 susp poll", {7'd0, s[7]}, 8'h01);
    chk("R4 tog held susp", {7'd0, s[6]}, {7'd0, e6});
    chk("R7 susp alt", {7'd0, s[2]}, {7'd0, e2});
    e2 = ~e2;
    in_ers = 1'b0;
    do_read();
    chk("R9 array sel", {7'd0, a}, 8'h01);
    chk("R9 status zero", s, 8'h00);
    in_ers = 1'b1;
    do_read();
    chk("R9 no adv + R4 held", {6'd0, s[6], s[2]}, {6'd0, e6, e2});
    e2 = ~e2;
    susp = 1'b0;
  endtask

  task automatic t_error();
    op = 2'b10;
    started = 1'b1;
    @(negedge clk);
    fail = 1'b1;
    @(negedge clk);
    fail = 1'b0;
    bfail = 1'b0;
    in_ers = 1'b1;
    do_read();
    chk("R5 fail set", {7'd0, s[5]}, 8'h01);
    chk("R8 alt pre", {7'd0, s[2]}, {7'd0, e2});
    e6 = ~e6;
    do_read();
    chk("R8 erasing but ok no adv", {7'd0, s[2]}, {7'd0, e2});
    e6 = ~e6;
    bfail = 1'b1;
    in_ers = 1'b0;
    do_read();
    e6 = ~e6;
    e2 = ~e2;
    bfail = 1'b0;
    op = 2'b00;
    do_read();
    chk("R8 failed blk adv", {7'd0, s[2]}, {7'd0, e2});
    chk("R5 idle still status", {7'd0, a, s[5]}, 8'h01);
    e6 = ~e6;
    @(negedge clk);
    rcmd = 1'b1;
    fail = 1'b1;
    @(negedge clk);
    rcmd = 1'b0;
    fail = 1'b0;
    peek();
    chk("R5 cleared", {7'd0, a}, 8'h01);
    chk("R1 idle status", s, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_program();
    t_erase();
    t_suspend();
    t_error();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule